// File: doc/BRIEF.md
# Floating-Point Issue Interlock for Multi-Latency Units

This block sits in the decode stage of an in-order pipeline. Next to the single-cycle integer path, that pipeline has a floating-point multiplier and a floating-point adder, and both are fully pipelined. For every floating-point register the block keeps a small countdown timer. When an instruction that writes such a register leaves decode, the block loads that register's timer with the total execute latency of the unit that will produce the value. Each cycle the block compares the timers of the current instruction's floating-point sources with a fixed threshold. From that comparison it decides whether the instruction issues now or waits in decode for one more cycle.

The surrounding pipeline uses the two outputs directly. `issue` means the instruction moves to execute at the next edge and a new one may enter decode. `stall` means the same instruction must be offered again in the next cycle. Timers keep counting down during a stall, so a wait is never longer than the dependency needs. The arithmetic, write-port arbitration, completion ordering and exceptions are handled elsewhere.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset every timer reads zero, both outputs are low while `in_valid` is low, and the first valid instruction issues with no stall, whatever its register fields.
- R2: In every cycle `issue` and `stall` are never high together, and exactly one of them is high when `in_valid` is high. Both are low when `in_valid` is low.
- R3: A floating-point load (kind 1) writes its destination one cycle later than an integer result would. A consumer offered right after the load stalls exactly one cycle. A consumer offered two or more cycles after the load does not stall.
- R4: A multiply (kind 3) result can be forwarded 7 cycles after the multiply issues, which is 1 plus 6 extra cycles. A dependent instruction offered in the very next cycle stalls 6 cycles.
- R5: An add (kind 4) result can be forwarded 4 cycles after the add issues, which is 1 plus 3 extra cycles. A dependent instruction offered in the next cycle stalls 3 cycles.
- R6: A store (kind 2) whose data register (`in_src_a`) comes from an add or multiply waits the same number of cycles as any other consumer of that result. Its data is needed in its memory stage, and results reach that stage from the producer's memory-stage latch.
- R7: Both units accept one operation per cycle. Back-to-back multiplies or adds with no register dependency issue without a stall.
- R8: Timers decrement during stalls and during unrelated instructions. A consumer that follows its producer by k cycles stalls max(0, latency - k) cycles.
- R9: Source fields are read only where the kind uses them. Integer ops (kind 0) and loads read none. A store reads only `in_src_a`. A multiply or add reads both sources. Fields that are not read never cause a stall.
- R10: The chain load, multiply that uses the load result, add that uses the product, store of the sum takes 18 cycles. The count runs from the load's fetch to the store's write-back, with fetch one cycle before decode and write-back three cycles after issue.
- R11: A cycle with `in_valid` low loads no timer, even if the other input fields describe a multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction occupies decode this cycle |
| in_kind | input | 3 | 0 integer, 1 FP load, 2 FP store, 3 FP multiply, 4 FP add |
| in_dst | input | REG_W | Floating-point destination register (kinds 1, 3, 4) |
| in_src_a | input | REG_W | First FP source (kinds 2, 3, 4); store data for kind 2 |
| in_src_b | input | REG_W | Second FP source (kinds 3, 4) |
| issue | output | 1 | Instruction leaves decode at the next edge |
| stall | output | 1 | Instruction is held in decode |

## Verification
The bench builds the block with its default parameters: 32 registers, 6 extra multiply cycles, 3 extra add cycles and a one-cycle load-use gap. These defaults reproduce the 18-cycle load/multiply/add/store chain exactly. With them the expected stall counts (1, 6, 3 and 4) differ from one another. A wrong latency, an off-by-one threshold or a timer that pauses during a stall therefore shows up as a stall count that does not match, at a known instruction. With 32 registers the tests can also use source fields that name busy registers while idle registers sit alongside them.

// File: rtl/fpil_pkg.sv
package fpil_pkg;
   typedef enum logic [2:0] {
      OP_INT    = 3'd0,
      OP_FLOAD  = 3'd1,
      OP_FSTORE = 3'd2,
      OP_FMUL   = 3'd3,
      OP_FADD   = 3'd4
   } op_kind_e;

   function automatic bit writes_freg(op_kind_e k);
      return (k == OP_FLOAD) || (k == OP_FMUL) || (k == OP_FADD);
   endfunction

   function automatic bit reads_src_a(op_kind_e k);
      return (k == OP_FSTORE) || (k == OP_FMUL) || (k == OP_FADD);
   endfunction

   function automatic bit reads_src_b(op_kind_e k);
      return (k == OP_FMUL) || (k == OP_FADD);
   endfunction
endpackage

// File: rtl/fpil_reg_timer.sv
module fpil_reg_timer #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - CNT_W'(1);
   end

   // R3 R4 R5: an issuing writer sets the timer to its unit latency
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));

   // R8: the timer keeps falling while no writer issues
   a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && count != '0) |=> count == $past(count) - CNT_W'(1));

   a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/fpil_src_check.sv
module fpil_src_check
   import fpil_pkg::*;
#(
   parameter int NUM_FREGS = 32,
   parameter int CNT_W     = 3,
   parameter int REG_W     = 5
) (
   input  op_kind_e         kind,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   input  logic [CNT_W-1:0] counts [NUM_FREGS],
   output logic             ready
);
   localparam logic [CNT_W-1:0] READY_MAX = CNT_W'(1);

   logic ok_a, ok_b;

   always_comb begin
      ok_a  = !reads_src_a(kind) || (counts[src_a] <= READY_MAX);
      ok_b  = !reads_src_b(kind) || (counts[src_b] <= READY_MAX);
      ready = ok_a && ok_b;
   end
endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
   import fpil_pkg::*;
#(
   parameter int NUM_FREGS    = 32,
   parameter int MUL_EXTRA    = 6,
   parameter int ADD_EXTRA    = 3,
   parameter int LOAD_USE_GAP = 1,
   localparam int REG_W       = $clog2(NUM_FREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_kind,
   input  logic [REG_W-1:0] in_dst,
   input  logic [REG_W-1:0] in_src_a,
   input  logic [REG_W-1:0] in_src_b,
   output logic             issue,
   output logic             stall
);
   localparam int MUL_LAT  = MUL_EXTRA + 1;
   localparam int ADD_LAT  = ADD_EXTRA + 1;
   localparam int LOAD_LAT = LOAD_USE_GAP + 1;
   localparam int MAX_LAT  = (MUL_LAT > ADD_LAT)
                             ? ((MUL_LAT > LOAD_LAT) ? MUL_LAT : LOAD_LAT)
                             : ((ADD_LAT > LOAD_LAT) ? ADD_LAT : LOAD_LAT);
   localparam int CNT_W    = $clog2(MAX_LAT + 1);

   initial begin
      assert (NUM_FREGS >= 2 && (1 << REG_W) == NUM_FREGS)
         else $error("NUM_FREGS must be a power of two, at least 2");
      assert (MUL_EXTRA >= 1 && ADD_EXTRA >= 1 && LOAD_USE_GAP >= 1)
         else $error("unit latencies must exceed one cycle");
   end

   op_kind_e         kind;
   logic             srcs_ready;
   logic [CNT_W-1:0] wr_latency;
   logic [CNT_W-1:0] timers [NUM_FREGS];

   assign kind = op_kind_e'(in_kind);

   always_comb begin
      unique case (kind)
         OP_FMUL:  wr_latency = CNT_W'(MUL_LAT);
         OP_FADD:  wr_latency = CNT_W'(ADD_LAT);
         OP_FLOAD: wr_latency = CNT_W'(LOAD_LAT);
         default:  wr_latency = '0;
      endcase
   end

   fpil_src_check #(
      .NUM_FREGS (NUM_FREGS),
      .CNT_W     (CNT_W),
      .REG_W     (REG_W)
   ) u_check (
      .kind   (kind),
      .src_a  (in_src_a),
      .src_b  (in_src_b),
      .counts (timers),
      .ready  (srcs_ready)
   );

   assign issue = in_valid && srcs_ready;
   assign stall = in_valid && !srcs_ready;

   for (genvar r = 0; r < NUM_FREGS; r++) begin : g_reg
      logic hit;
      assign hit = issue && writes_freg(kind) && (in_dst == REG_W'(r));

      fpil_reg_timer #(.CNT_W(CNT_W)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (hit),
         .load_val (wr_latency),
         .count    (timers[r])
      );
   end

   // R2: the two outcomes exclude each other
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue, stall}));

   // R2: an empty decode slot yields neither outcome
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!issue && !stall));

   // R9: integer ops and loads read no FP source, so they never wait
   a_r9_no_src_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (kind == OP_INT || kind == OP_FLOAD)) |-> issue);

   // R11: an empty slot writes no timer
   a_r11_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (timers[$past(in_dst)] <= $past(timers[in_dst])));
endmodule

// File: tb/sim_fp_issue_interlock.sv
module sim_fp_issue_interlock;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_kind = 3'd0;
   logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic          issue, stall;

   fp_issue_interlock u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .issue(issue), .stall(stall)
   );

   always #2.5 clk = ~clk;

   int    checks = 0, errors = 0, cyc = 0;
   int    exp_q[$];
   string tag_q[$];
   int    run_stalls = 0, last_issue_cyc = 0;
   bit    seen_issue = 0, done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: samples half a cycle after the edge
   always begin
      @(negedge clk); #1;
      if (rst_n) begin
         checks++;
         if ((issue && stall) || (in_valid != (issue || stall))) begin
            errors++;
            $display("FAIL R2: issue=%0b stall=%0b valid=%0b (expected one outcome per valid slot)",
                     issue, stall, in_valid);
         end
         if (stall) run_stalls++;
         if (issue) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (run_stalls != e) begin
               errors++;
               $display("FAIL %s: stall cycles %0d, expected %0d", t, run_stalls, e);
            end
            run_stalls = 0;
            last_issue_cyc = cyc;
            seen_issue = 1;
         end
      end
   end

   task automatic send(input logic [2:0] k, input int d, input int a, input int b,
                       input int exp_stalls, input string tag);
      exp_q.push_back(exp_stalls);
      tag_q.push_back(tag);
      in_valid = 1'b1; in_kind = k;
      in_dst = RW'(d); in_src_a = RW'(a); in_src_b = RW'(b);
      do begin @(posedge clk); #1; end while (!seen_issue);
      seen_issue = 0;
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int first_id;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #2;
      checks++;
      if (issue || stall) begin
         errors++;
         $display("FAIL R1: issue=%0b stall=%0b, expected 0 0 after reset", issue, stall);
      end
      @(posedge clk); #1;
      send(3'd4, 1, 2, 3, 0, "R1 first add after reset");
      idle(8);

      // load / multiply / add / store chain
      first_id = cyc;
      send(3'd1, 4, 0, 0, 0, "R10 load");
      send(3'd3, 0, 4, 6, 1, "R3 multiply after load");
      send(3'd4, 2, 0, 8, 6, "R4 add after multiply");
      send(3'd2, 0, 2, 0, 3, "R6 store of sum");
      checks++;
      if (last_issue_cyc - first_id + 5 != 18) begin
         errors++;
         $display("FAIL R10: chain took %0d cycles, expected 18", last_issue_cyc - first_id + 5);
      end
      idle(8);

      send(3'd3, 1, 2, 3, 0, "R7 mul");
      send(3'd3, 5, 6, 7, 0, "R7 mul back to back");
      send(3'd4, 9, 10, 11, 0, "R7 add");
      send(3'd4, 12, 13, 14, 0, "R7 add back to back");
      send(3'd4, 15, 12, 9, 3, "R5 add on add");
      idle(8);

      send(3'd3, 20, 1, 2, 0, "R8 mul");
      send(3'd0, 0, 0, 0, 0, "R8 int");
      send(3'd0, 0, 0, 0, 0, "R8 int");
      send(3'd4, 21, 20, 3, 4, "R8 add after gap");
      idle(8);

      send(3'd3, 22, 1, 2, 0, "R9 mul");
      send(3'd0, 0, 22, 22, 0, "R9 int ignores sources");
      send(3'd1, 23, 22, 22, 0, "R9 load ignores sources");
      send(3'd2, 0, 24, 22, 0, "R9 store ignores src_b");
      send(3'd2, 0, 22, 0, 3, "R9 R6 store data from mul");
      idle(8);

      send(3'd1, 25, 0, 0, 0, "R3 load");
      send(3'd4, 26, 25, 1, 1, "R3 adjacent use");
      send(3'd1, 27, 0, 0, 0, "R3 load");
      send(3'd0, 0, 0, 0, 0, "R3 int");
      send(3'd4, 28, 1, 27, 0, "R3 use after gap");
      idle(8);

      in_kind = 3'd3; in_dst = RW'(29);
      idle(2);
      send(3'd4, 30, 29, 29, 0, "R11 empty slot wrote nothing");

      idle(2);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: %0d instructions never issued, expected 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule